// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block watches bus cycles and raises a bus error when a cycle is not acknowledged within a programmable number of system clocks. A cycle-start strobe begins a cycle. An acknowledge input ends it. A flag marks each cycle as internal or external. A small control register sets three things: the timeout length, whether external cycles are watched, and whether a double-fault detector may halt the system.

The timeout comes from a 2-bit field that picks one of four power-of-two lengths. External cycles are watched only when an active-low enable bit is cleared. That bit is set after reset, so external cycles are not watched by default. Internal cycles are always watched.

Each timeout produces a bus-error pulse and marks a fault as pending. An acknowledged cycle clears the pending fault. If a second timeout arrives while a fault is still pending and the double-fault enable is set, a sticky halt output rises. Only reset clears it.

Top module: `bus_timeout_mon`

## Requirements
- R1: After reset the control register reads 4'b1100, and both bus_err_o and halt_o are low.
- R2: The control register has the layout [1:0] timeout select, [2] external-monitor disable (1 = external cycles not watched), [3] double-fault enable. A write takes effect at the clock edge where reg_we_i is sampled, and reg_rdata_o always shows the stored value.
- R3: The timeout select maps 00 to 1024 clocks, 01 to 512, 10 to 256 and 11 to 128. For a watched cycle that gets no acknowledge, bus_err_o is high in the clock that follows the Nth rising edge after the start edge.
- R4: An acknowledge sampled on any edge from the first to the Nth after the start edge ends the cycle with no bus error.
- R5: Internal cycles (cyc_ext_i = 0) are watched whatever the external-monitor disable bit holds.
- R6: An external cycle is watched only when the external-monitor disable bit is 0 at its start edge. Otherwise that cycle never raises a bus error.
- R7: The timeout select and the external-monitor disable bit are captured at the start edge. Writes made during a running cycle do not change that cycle's timeout or its watched state.
- R8: Each timeout raises bus_err_o for exactly one clock.
- R9: A timeout that occurs while a fault is pending, with the double-fault enable set, raises halt_o one clock after that bus error. halt_o then stays high until reset.
- R10: An acknowledge clears the pending fault, so a later single timeout does not halt. With the double-fault enable cleared, halt_o never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_start_i | input | 1 | Bus cycle start strobe |
| cyc_ack_i | input | 1 | Bus cycle acknowledge |
| cyc_ext_i | input | 1 | Cycle is external (sampled with start) |
| reg_we_i | input | 1 | Control register write enable |
| reg_wdata_i | input | 4 | Control register write data |
| reg_rdata_o | output | 4 | Control register read data |
| bus_err_o | output | 1 | Bus error pulse |
| halt_o | output | 1 | Sticky double-fault halt |

## Verification
A bus error is due in the clock after the Nth rising edge that follows the start edge. The halt follows one edge after the bus error that causes it. A register write shows on the read port one edge after it is sampled. The bench drives inputs and samples outputs on the falling edge. For each cycle it counts the falling edges since the start edge and records the index at which it sees the error. It then compares that index and the number of errors against the N the bench computes from the timeout select. The halt is checked several clocks after the last error, and the read-back is checked at the falling edge after the write.

// File: rtl/btm_pkg.sv
package btm_pkg;
  localparam int TSEL_W = 2;

  typedef struct packed {
    logic              dbl_en;
    logic              ext_dis;
    logic [TSEL_W-1:0] tsel;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  localparam ctl_t CTL_RST = '{dbl_en: 1'b1, ext_dis: 1'b1, tsel: '0};
endpackage

// File: rtl/btm_ctrl_reg.sv
module btm_ctrl_reg
  import btm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output ctl_t             ctl_o
);
  ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= CTL_RST;
    else if (we_i) ctl_q <= ctl_t'(wdata_i);
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/btm_timer.sv
module btm_timer #(
  parameter int BASE_LOG2 = 7,
  parameter int TSEL_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              watch_i,
  input  logic              ack_i,
  input  logic [TSEL_W-1:0] tsel_i,
  output logic              expire_o
);
  localparam int MAX_SHIFT = (1 << TSEL_W) - 1;
  localparam int CNT_W     = BASE_LOG2 + MAX_SHIFT + 1;

  logic             active_q, expire_q;
  logic [CNT_W-1:0] cnt_q, term_q, term_d;
  int               shamt;
  logic             hit;

  // longest window at select 0, halving per step
  always_comb begin
    shamt  = BASE_LOG2 + MAX_SHIFT - int'(tsel_i);
    term_d = (CNT_W'(1) << shamt) - CNT_W'(1);
  end

  assign hit = active_q && !ack_i && (cnt_q == term_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      term_q   <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= !start_i && hit;
      if (start_i) begin
        active_q <= watch_i;
        cnt_q    <= '0;
        term_q   <= term_d;
      end else if (active_q) begin
        if (ack_i || hit) active_q <= 1'b0;
        else              cnt_q    <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign expire_o = expire_q;
endmodule

// File: rtl/btm_fault.sv
module btm_fault (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic ack_i,
  input  logic dbl_en_i,
  output logic halt_o
);
  logic pend_q, halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      if (expire_i) begin
        pend_q <= 1'b1;
        if (pend_q && dbl_en_i) halt_q <= 1'b1;
      end else if (ack_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign halt_o = halt_q;
endmodule

// File: rtl/bus_timeout_mon.sv
module bus_timeout_mon
  import btm_pkg::*;
#(
  parameter int BASE_LOG2 = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_start_i,
  input  logic             cyc_ack_i,
  input  logic             cyc_ext_i,
  input  logic             reg_we_i,
  input  logic [CTL_W-1:0] reg_wdata_i,
  output logic [CTL_W-1:0] reg_rdata_o,
  output logic             bus_err_o,
  output logic             halt_o
);
  ctl_t ctl;
  logic watch, expire;

  btm_ctrl_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .ctl_o   (ctl)
  );

  assign watch = !cyc_ext_i || !ctl.ext_dis;

  btm_timer #(.BASE_LOG2(BASE_LOG2), .TSEL_W(TSEL_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (cyc_start_i),
    .watch_i  (watch),
    .ack_i    (cyc_ack_i),
    .tsel_i   (ctl.tsel),
    .expire_o (expire)
  );

  btm_fault u_flt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .ack_i    (cyc_ack_i),
    .dbl_en_i (ctl.dbl_en),
    .halt_o   (halt_o)
  );

  assign reg_rdata_o = ctl;
  assign bus_err_o   = expire;
endmodule

// File: rtl/btm_checker.sv
module btm_checker #(
  parameter int MIN_LIMIT = 128
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cyc_start_i,
  input logic       cyc_ack_i,
  input logic       cyc_ext_i,
  input logic [3:0] reg_rdata_o,
  input logic       bus_err_o,
  input logic       halt_o
);
  logic [11:0] gap_q;
  logic        unwatched_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q       <= '1;
      unwatched_q <= 1'b0;
    end else if (cyc_start_i) begin
      gap_q       <= '0;
      unwatched_q <= cyc_ext_i && reg_rdata_o[2];
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 12'd1;
    end
  end

  AST_ERR_MIN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> (gap_q >= 12'(MIN_LIMIT))); // R3
  AST_ACK_BLOCKS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_ack_i |=> !bus_err_o); // R4
  AST_EXT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> !unwatched_q); // R6
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |=> !bus_err_o); // R8
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o); // R9
  AST_HALT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> $past(bus_err_o)); // R9
endmodule

bind bus_timeout_mon btm_checker u_chk (.*);

// File: tb/sim_bus_timeout_mon.sv
module sim_bus_timeout_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, ack = 1'b0, ext = 1'b0, we = 1'b0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic       berr, halt;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  localparam int RUN_LEN = 1040;
  localparam int NVEC    = 12;
  // {tsel[1:0], ext, ext_dis, ack_at[11:0]}; ack_at 0 = never
  localparam logic [15:0] VEC [NVEC] = '{
    {2'b00, 1'b0, 1'b1, 12'd0},
    {2'b01, 1'b0, 1'b1, 12'd0},
    {2'b10, 1'b0, 1'b0, 12'd0},
    {2'b11, 1'b0, 1'b0, 12'd0},
    {2'b11, 1'b1, 1'b0, 12'd0},
    {2'b11, 1'b1, 1'b1, 12'd0},
    {2'b11, 1'b0, 1'b0, 12'd128},
    {2'b11, 1'b0, 1'b0, 12'd129},
    {2'b10, 1'b1, 1'b0, 12'd100},
    {2'b01, 1'b0, 1'b1, 12'd511},
    {2'b00, 1'b1, 1'b1, 12'd0},
    {2'b10, 1'b1, 1'b0, 12'd257}
  };

  always #4 clk = ~clk;

  bus_timeout_mon u0 (
    .clk_i(clk), .rst_ni(rst_n), .cyc_start_i(start), .cyc_ack_i(ack),
    .cyc_ext_i(ext), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .bus_err_o(berr), .halt_o(halt)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] v);
    @(negedge clk);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  // start edge is edge 0; records falling-edge index of each error seen
  task automatic run_cycle(input logic is_ext, input int ack_at, input int wr_at,
                           input logic [3:0] wr_val, output int n_err, output int err_at);
    n_err = 0; err_at = -1;
    @(negedge clk);
    start = 1'b1; ext = is_ext;
    @(negedge clk);
    start = 1'b0; ext = 1'b0;
    ack = (ack_at == 1);
    we = (wr_at == 1); wdata = wr_val;
    for (int k = 1; k <= RUN_LEN; k++) begin
      @(negedge clk);
      if (berr) begin n_err++; err_at = k; end
      ack = (k + 1 == ack_at);
      we  = (k + 1 == wr_at);
    end
    ack = 1'b0; we = 1'b0;
  endtask

  function automatic int limit_of(input logic [1:0] ts);
    return 1024 >> ts;
  endfunction

  initial begin
    int n, at, lim, exp_n;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset reg", int'(rdata), 12);
    check("R1 reset berr", int'(berr), 0);
    check("R1 reset halt", int'(halt), 0);

    run_cycle(1'b1, 0, 0, 4'h0, n, at);
    check("R6 default ext unwatched", n, 0);
    run_cycle(1'b0, 0, 0, 4'h0, n, at);
    check("R5 internal watched count", n, 1);
    check("R5 internal watched at", at, 1024);
    run_cycle(1'b0, 5, 0, 4'h0, n, at);
    check("R4 early ack", n, 0);

    wr_reg(4'h5);
    check("R2 readback", int'(rdata), 5);
    wr_reg(4'hA);
    check("R2 readback", int'(rdata), 10);

    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      wr_reg({1'b0, v[12], v[15:14]});
      lim = limit_of(v[15:14]);
      exp_n = ((!v[13] || !v[12]) && (v[11:0] == 0 || int'(v[11:0]) > lim)) ? 1 : 0;
      run_cycle(v[13], int'(v[11:0]), 0, 4'h0, n, at);
      check($sformatf("R3 R4 R5 R6 R8 vec%0d count", i), n, exp_n);
      if (exp_n == 1) check($sformatf("R3 vec%0d timing", i), at, lim);
    end
    check("R10 no halt with dbl off", int'(halt), 0);

    wr_reg(4'b0011);
    run_cycle(1'b1, 0, 10, 4'b0100, n, at);
    check("R7 mid write count", n, 1);
    check("R7 mid write at", at, 128);
    check("R7 readback after mid write", int'(rdata), 4);

    run_cycle(1'b0, 3, 0, 4'h0, n, at);
    wr_reg(4'b1011);
    run_cycle(1'b0, 0, 0, 4'h0, n, at);
    check("R9 single fault no halt", int'(halt), 0);
    run_cycle(1'b0, 3, 0, 4'h0, n, at);
    run_cycle(1'b0, 0, 0, 4'h0, n, at);
    check("R10 ack cleared pending", int'(halt), 0);
    run_cycle(1'b0, 0, 0, 4'h0, n, at);
    check("R9 double fault halts", int'(halt), 1);
    run_cycle(1'b0, 3, 0, 4'h0, n, at);
    check("R9 halt sticky", int'(halt), 1);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears halt", int'(halt), 0);
    check("R1 reset reg again", int'(rdata), 12);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule